// File: doc/BRIEF.md
# Phase-Window SYSREF Alignment

This block times the rising edge of a SYSREF input to a quarter of a device-clock period. From that timing it picks the device-clock rising edge on which the frame counter and the multiframe (LMFC) counter restart. The block runs on one sampling clock at four times the device-clock rate. A free-running 2-bit quarter counter marks the four phases of every device cycle. Value 0 of that counter is the first quarter after a device-clock rising edge.

A 2-bit window select places a tolerance span, four quarters wide, around the point where the SYSREF edge is expected. Every edge that falls inside one span produces the same alignment edge, so board skew inside the span has no effect on where the counters restart. A signed offset of one device cycle can then move the chosen edge earlier or later. This lets the late windows reach the same edge as the early ones, or lets the early windows be pushed back by one cycle. When the chosen edge arrives, the block issues a single alignment pulse and both counters start again from zero.

Top module: `sysrefPhaseAlign`

## Requirements
- R1: While `rstN` is low and in the first sampling cycle after its release, `devPhase` is 0, `alignPulse` is 0, and `frameCnt` and `lmfcCnt` are 0.
- R2: `devPhase` advances by one, modulo 4, every `clk4x` cycle. Values 0..3 are the quarters q1..q4. Device cycle n is the four cycles whose `devPhase` runs 0 to 3, and its rising edge lies at the start of the cycle with `devPhase` 0.
- R3: A SYSREF edge is a `clk4x` cycle in which `sysref` is high after a cycle in which it was low. Its quarter is the `devPhase` value of that cycle. The edge is acted on two cycles later, after the synchronizer, and only if `sysrefEnable` is high in that later cycle; otherwise it has no effect.
- R4: `windowSel` 00 covers q4 of cycle n-1 through q3 of cycle n, and 01 covers q1 through q4 of cycle n. With offset 0 both give `alignPulse` in the `devPhase`-0 cycle that starts device cycle n+2.
- R5: `windowSel` 10 covers q2 of cycle n through q1 of cycle n+1, and 11 covers q3 of cycle n through q2 of cycle n+1. With offset 0 both give the pulse at the start of cycle n+3, one device cycle later than windows 00/01.
- R6: `alignOffset` 11 (-1) moves the pulse for windows 10 and 11 one device cycle earlier, onto the edge that windows 00/01 use.
- R7: `alignOffset` 01 (+1) moves the pulse one device cycle later for every window. Code 00 and the reserved code 10 mean zero, and -1 has no effect on windows 00 and 01. `windowSel` and `alignOffset` are read in the cycle in which the edge is acted on.
- R8: `alignPulse` lasts exactly one `clk4x` cycle, always in a cycle with `devPhase` 0, and in that cycle `frameCnt` and `lmfcCnt` both read 0.
- R9: Apart from realignment, `frameCnt` steps once per device cycle and returns to 0 when its next value would reach `frameLen`. `lmfcCnt` steps each time `frameCnt` returns to 0, and itself returns to 0 when its next value would reach `lmfcLen`. Both counters change only on entering `devPhase` 0.
- R10: An edge acted on while an earlier alignment is still waiting replaces it: only the newest edge's pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk4x | input | 1 | Sampling clock, four times the device clock |
| rstN | input | 1 | Active-low synchronous reset |
| sysref | input | 1 | Asynchronous SYSREF input |
| sysrefEnable | input | 1 | Enables action on detected edges |
| windowSel | input | 2 | Tolerance window select |
| alignOffset | input | 2 | Alignment offset, two's complement, 10 reserved |
| frameLen | input | CNT_W | Device cycles per frame |
| lmfcLen | input | CNT_W | Frames per multiframe |
| devPhase | output | 2 | Current quarter of the device cycle |
| alignPulse | output | 1 | One-cycle realignment strobe |
| frameCnt | output | CNT_W | Device cycle within the frame |
| lmfcCnt | output | CNT_W | Frame within the multiframe |

## Verification
Some properties are checked on every cycle. The quarter counter advances steadily, and the pulse lasts one cycle, falls on quarter q1 and finds both counters at zero. The counters stay still inside a device cycle, and the multiframe count changes only when the frame count returns to zero. Which edge a given quarter, window and offset select can only be shown by the bench's scenarios, as can the enable gating and the replacement of a waiting alignment. The bench sweeps all four quarters against every window and offset code and compares against its own reference model.

// File: rtl/sysrefAlignPkg.sv
`timescale 1ns/1ps
package sysrefAlignPkg;
  // quarters per device-clock period and synchronizer length
  localparam int unsigned QUARTERS   = 4;
  localparam int unsigned SYNC_DEPTH = 2;

  // datapath -> control: what was seen this cycle
  typedef struct packed {
    logic       edgeSeen;
    logic [1:0] phaseNow;
  } dpStatus_t;

  // control -> datapath: strobes
  typedef struct packed {
    logic realign;   // restart counters at the coming device edge
  } ctlStrobe_t;
endpackage

// File: rtl/sysrefPhaseDatapath.sv
`timescale 1ns/1ps
module sysrefPhaseDatapath
  import sysrefAlignPkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk4x,
  input  logic             rstN,
  input  logic             sysref,
  input  logic [CNT_W-1:0] frameLen,
  input  logic [CNT_W-1:0] lmfcLen,
  input  ctlStrobe_t       ctl,
  output dpStatus_t        stat,
  output logic [1:0]       devPhase,
  output logic             alignPulse,
  output logic [CNT_W-1:0] frameCnt,
  output logic [CNT_W-1:0] lmfcCnt
);
  localparam logic [1:0] LAST_Q = 2'(QUARTERS - 1);

  logic [SYNC_DEPTH-1:0] syncQ;
  logic                  prevQ;
  logic [1:0]            qPhase;
  logic                  devEdgeNext;
  logic [CNT_W:0]        frameNext;
  logic [CNT_W:0]        lmfcNext;
  logic                  frameWrap;
  logic                  lmfcWrap;

  // two-flop synchronizer followed by an edge detector
  always_ff @(posedge clk4x) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_DEPTH-2:0], sysref};
      prevQ <= syncQ[SYNC_DEPTH-1];
    end
  end

  // quarter-phase counter, 0 right after a device-clock rising edge
  always_ff @(posedge clk4x) begin
    if (!rstN) qPhase <= '0;
    else       qPhase <= qPhase + 2'd1;
  end

  assign devEdgeNext   = (qPhase == LAST_Q);
  assign stat.edgeSeen = syncQ[SYNC_DEPTH-1] & ~prevQ;
  assign stat.phaseNow = qPhase;

  assign frameNext = {1'b0, frameCnt} + 1'b1;
  assign lmfcNext  = {1'b0, lmfcCnt} + 1'b1;
  assign frameWrap = (frameNext >= {1'b0, frameLen});
  assign lmfcWrap  = (lmfcNext >= {1'b0, lmfcLen});

  always_ff @(posedge clk4x) begin
    if (!rstN) begin
      frameCnt   <= '0;
      lmfcCnt    <= '0;
      alignPulse <= 1'b0;
    end else begin
      alignPulse <= ctl.realign & devEdgeNext;
      if (devEdgeNext) begin
        if (ctl.realign) begin
          frameCnt <= '0;
          lmfcCnt  <= '0;
        end else if (frameWrap) begin
          frameCnt <= '0;
          lmfcCnt  <= lmfcWrap ? '0 : lmfcNext[CNT_W-1:0];
        end else begin
          frameCnt <= frameNext[CNT_W-1:0];
        end
      end
    end
  end

  assign devPhase = qPhase;
endmodule

// File: rtl/sysrefAlignControl.sv
`timescale 1ns/1ps
module sysrefAlignControl
  import sysrefAlignPkg::*;
(
  input  logic       clk4x,
  input  logic       rstN,
  input  logic       sysrefEnable,
  input  logic [1:0] windowSel,
  input  logic [1:0] alignOffset,
  input  dpStatus_t  stat,
  output ctlStrobe_t ctl
);
  logic [1:0] edgeQuarter;
  logic [2:0] baseEdges;
  logic       plusOne;
  logic       minusOne;
  logic [2:0] edgesAhead;
  logic [4:0] waitCycles;
  logic       take;
  logic       pending;
  logic [3:0] remain;

  // quarter in which the raw edge happened, undoing synchronizer delay
  assign edgeQuarter = 2'(stat.phaseNow - 2'(SYNC_DEPTH));

  // device edges past the edge's own cycle, before offset and latency
  always_comb begin
    unique case (windowSel)
      2'b00:   baseEdges = (edgeQuarter == 2'd3) ? 3'd2 : 3'd1;
      2'b01:   baseEdges = 3'd1;
      2'b10:   baseEdges = (edgeQuarter == 2'd0) ? 3'd1 : 3'd2;
      default: baseEdges = (edgeQuarter <= 2'd1) ? 3'd1 : 3'd2;
    endcase
  end

  assign plusOne    = (alignOffset == 2'b01);
  assign minusOne   = (alignOffset == 2'b11) && windowSel[1];
  assign edgesAhead = baseEdges + {2'b00, plusOne} - {2'b00, minusOne};

  // sampling cycles from now until the chosen q1 cycle (one cycle of latency added)
  assign waitCycles = {edgesAhead + 3'd1, 2'b00} - {3'b000, edgeQuarter}
                    - 5'(SYNC_DEPTH);

  assign take = stat.edgeSeen & sysrefEnable;

  always_ff @(posedge clk4x) begin
    if (!rstN) begin
      pending <= 1'b0;
      remain  <= '0;
    end else if (take) begin
      pending <= (waitCycles != 5'd1);
      remain  <= 4'(waitCycles - 5'd2);
    end else if (pending) begin
      if (remain == '0) pending <= 1'b0;
      else              remain  <= remain - 4'd1;
    end
  end

  // a fresh edge overrides whatever was waiting
  assign ctl.realign = take ? (waitCycles == 5'd1) : (pending && remain == '0);
endmodule

// File: rtl/sysrefPhaseAlign.sv
`timescale 1ns/1ps
module sysrefPhaseAlign
  import sysrefAlignPkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk4x,
  input  logic             rstN,
  input  logic             sysref,
  input  logic             sysrefEnable,
  input  logic [1:0]       windowSel,
  input  logic [1:0]       alignOffset,
  input  logic [CNT_W-1:0] frameLen,
  input  logic [CNT_W-1:0] lmfcLen,
  output logic [1:0]       devPhase,
  output logic             alignPulse,
  output logic [CNT_W-1:0] frameCnt,
  output logic [CNT_W-1:0] lmfcCnt
);
  dpStatus_t  stat;
  ctlStrobe_t ctl;

  sysrefPhaseDatapath #(.CNT_W(CNT_W)) dp (
    .clk4x(clk4x), .rstN(rstN), .sysref(sysref),
    .frameLen(frameLen), .lmfcLen(lmfcLen), .ctl(ctl), .stat(stat),
    .devPhase(devPhase), .alignPulse(alignPulse),
    .frameCnt(frameCnt), .lmfcCnt(lmfcCnt)
  );

  sysrefAlignControl ctrl (
    .clk4x(clk4x), .rstN(rstN), .sysrefEnable(sysrefEnable),
    .windowSel(windowSel), .alignOffset(alignOffset),
    .stat(stat), .ctl(ctl)
  );
endmodule

// File: rtl/sysrefPhaseAlignChecker.sv
`timescale 1ns/1ps
module sysrefPhaseAlignChecker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk4x,
  input logic             rstN,
  input logic [1:0]       devPhase,
  input logic             alignPulse,
  input logic [CNT_W-1:0] frameCnt,
  input logic [CNT_W-1:0] lmfcCnt
);
  logic started;
  always_ff @(posedge clk4x) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  a_r2_phase_steps: assert property (@(posedge clk4x) disable iff (!rstN)
    started |-> devPhase == 2'($past(devPhase) + 2'd1));

  a_r8_pulse_on_q1: assert property (@(posedge clk4x) disable iff (!rstN)
    alignPulse |-> devPhase == 2'd0);

  a_r8_pulse_single: assert property (@(posedge clk4x) disable iff (!rstN)
    alignPulse |=> !alignPulse);

  a_r8_counters_zero: assert property (@(posedge clk4x) disable iff (!rstN)
    alignPulse |-> (frameCnt == '0 && lmfcCnt == '0));

  a_r9_hold_in_cycle: assert property (@(posedge clk4x) disable iff (!rstN)
    (started && devPhase != 2'd0) |-> ($stable(frameCnt) && $stable(lmfcCnt)));

  a_r9_lmfc_on_wrap: assert property (@(posedge clk4x) disable iff (!rstN)
    (started && !alignPulse && lmfcCnt != $past(lmfcCnt)) |-> frameCnt == '0);
endmodule

bind sysrefPhaseAlign sysrefPhaseAlignChecker #(.CNT_W(CNT_W)) chk (
  .clk4x(clk4x), .rstN(rstN), .devPhase(devPhase), .alignPulse(alignPulse),
  .frameCnt(frameCnt), .lmfcCnt(lmfcCnt)
);

// File: tb/sysrefPhaseAlign_test.sv
`timescale 1ns/1ps
module sysrefPhaseAlign_test;
  localparam int CNT_W = 8;

  logic             clk4x = 1'b0;
  logic             rstN = 1'b0;
  logic             sysref = 1'b0;
  logic             sysrefEnable = 1'b1;
  logic [1:0]       windowSel = 2'b00;
  logic [1:0]       alignOffset = 2'b00;
  logic [CNT_W-1:0] frameLen = 8'd3;
  logic [CNT_W-1:0] lmfcLen = 8'd2;
  logic [1:0]       devPhase;
  logic             alignPulse;
  logic [CNT_W-1:0] frameCnt;
  logic [CNT_W-1:0] lmfcCnt;

  sysrefPhaseAlign #(.CNT_W(CNT_W)) uut (
    .clk4x(clk4x), .rstN(rstN), .sysref(sysref), .sysrefEnable(sysrefEnable),
    .windowSel(windowSel), .alignOffset(alignOffset), .frameLen(frameLen),
    .lmfcLen(lmfcLen), .devPhase(devPhase), .alignPulse(alignPulse),
    .frameCnt(frameCnt), .lmfcCnt(lmfcCnt)
  );

  always #4 clk4x = ~clk4x;   // 125 MHz

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // stimulus for the next cycle
  bit srNext = 0, enNext = 1;
  int wNext = 0, offNext = 0, fLenNext = 3, lLenNext = 2;
  string pulseTag = "R4";

  // reference model state
  int t = 0;
  int tgt = -1;
  int expFrame = 0, expLmfc = 0;
  bit h0 = 0, h1 = 0, h2 = 0, h3 = 0;   // sysref in cycles t, t-1, t-2, t-3

  task automatic check(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s at t=%0d: actual %0d expected %0d", tag, what, t, act, exp);
    end
  endtask

  // cycle index of the q1 cycle carrying the pulse for an edge in cycle e
  function automatic int targetOf(input int e, input int w, input int off);
    int spanStart, owner, base, adj;
    spanStart = w - 1;                        // quarter offset where the span begins
    owner = (e - spanStart + 4) / 4 - 1;      // device cycle that owns the span
    base = (w >= 2) ? 2 : 1;
    adj = 0;
    if (off == 1) adj = 1;
    else if (off == 3 && w >= 2) adj = -1;
    return 4 * (owner + base + adj + 1);
  endfunction

  task automatic step();
    bit expPulse;
    string ctag;
    @(negedge clk4x);
    expPulse = (tgt == t);
    if (t > 0 && t % 4 == 0) begin
      if (expPulse) begin
        expFrame = 0; expLmfc = 0;
      end else if (expFrame + 1 >= int'(frameLen)) begin
        expFrame = 0;
        expLmfc = (expLmfc + 1 >= int'(lmfcLen)) ? 0 : expLmfc + 1;
      end else expFrame++;
    end
    if (t == 0) begin   // R1 reset state
      check("R1", "devPhase", devPhase, 0);
      check("R1", "alignPulse", alignPulse, 0);
      check("R1", "frameCnt", frameCnt, 0);
      check("R1", "lmfcCnt", lmfcCnt, 0);
    end else begin
      ctag = expPulse ? "R8" : "R9";
      check("R2", "devPhase", devPhase, t % 4);
      check(pulseTag, "alignPulse", alignPulse, expPulse);
      check(ctag, "frameCnt", frameCnt, expFrame);
      check(ctag, "lmfcCnt", lmfcCnt, expLmfc);
    end
    // drive inputs for cycle t
    rstN = 1'b1;
    sysref = srNext;
    sysrefEnable = enNext;
    windowSel = 2'(wNext);
    alignOffset = 2'(offNext);
    frameLen = 8'(fLenNext);
    lmfcLen = 8'(lLenNext);
    h3 = h2; h2 = h1; h1 = h0; h0 = srNext;
    if (h2 && !h3 && enNext) tgt = targetOf(t - 2, wNext, offNext);
    t++;
  endtask

  task automatic edgeAt(input int p, input int holdHigh, input int tail);
    while (t % 4 != p) step();
    srNext = 1;
    repeat (holdHigh) step();
    srNext = 0;
    repeat (tail) step();
  endtask

  initial begin
    repeat (3) @(posedge clk4x);
    repeat (6) step();
    // R4..R7: every quarter against every window and offset code
    for (int w = 0; w < 4; w++) begin
      fLenNext = (w == 0) ? 1 : w + 2;
      lLenNext = 3;
      wNext = w;
      for (int off = 0; off < 4; off++) begin
        offNext = off;
        if (off == 1 || off == 2) pulseTag = "R7";
        else if (off == 3) pulseTag = (w >= 2) ? "R6" : "R7";
        else pulseTag = (w >= 2) ? "R5" : "R4";
        for (int p = 0; p < 4; p++) edgeAt(p, 3, 20);
      end
    end
    // R3: edge with the enable low must not realign
    pulseTag = "R3";
    wNext = 0; offNext = 0; enNext = 0;
    edgeAt(1, 3, 20);
    enNext = 1;
    edgeAt(2, 2, 20);
    // R10: second edge replaces a still-waiting alignment
    pulseTag = "R10";
    wNext = 3; offNext = 1;
    edgeAt(2, 2, 3);
    wNext = 1; offNext = 0;
    edgeAt(3, 2, 24);
    // R9: longer counter run with other lengths
    pulseTag = "R9";
    fLenNext = 5; lLenNext = 4;
    repeat (120) step();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule